// File: doc/BRIEF.md
# Top-Plate SAR Conversion Controller

This block sequences a charge-redistribution successive-approximation converter whose input is sampled onto the top plates of a binary-weighted capacitor array. A rising edge on the sampling clock, seen while the controller is parked, starts a conversion. Every bottom plate starts at the reference voltage, and the first comparison is taken before any plate moves. Each later decision can only move one bottom plate from reference to ground.

The controller is self-timed by the comparator. It forms a valid strobe as the NAND of the two comparator rails, which both rest high while the comparator is held in reset. It drives the comparator clock high whenever the bit chain is parked, the strobe is up or the sampling clock is high. A one-hot step chain walks from the most significant bit to the least. Each per-bit cell latches the decision on its step and then, one cycle later, grounds its plate if that decision was 1. After the tenth decision the result word is loaded and a one-cycle done pulse is given.

Everything runs on one system clock. The sampling clock and the comparator rails are sampled as synchronous inputs.

Top module: `tps_sar_ctrl`

## Requirements
- R1: While rst is high at a clock edge, the next state has step_o all zero, plate_gnd_o all zero (every plate at reference), code_o zero, done_o low and cmp_clk_o high. In this state the chain is parked.
- R2: A rising edge of sample_clk_i (high now, low at the previous edge) while parked starts a conversion. At the next edge step_o becomes the MSB one-hot value (bit NB-1 set) and plate_gnd_o is cleared, so the first comparison sees no grounded plate.
- R3: cmp_clk_o is registered. After each edge it equals the OR of sample_clk_i, valid and the parked flag as they were at that edge, where valid = NOT(cmp_p_i AND cmp_n_i).
- R4: A rising edge of valid while a step is active latches the decision, which is the value of cmp_p_i: 1 means the positive rail stayed high and the negative rail fell. The same edge moves the one-hot step_o one position toward bit 0. After bit 0 the chain parks with step_o zero.
- R5: One cycle after bit k's decision is latched, plate_gnd_o[k] becomes 1 if the decision was 1 and stays 0 otherwise (1 = ground, 0 = reference). A plate never returns from ground to reference except at the start of a conversion.
- R6: One cycle after bit 0's decision is latched, done_o is high for exactly one cycle. In that cycle code_o[k] holds bit k's decision and equals plate_gnd_o[k]. Driven by an ideal comparator, code_o equals the ideal 10-bit quantisation of the input, including zero, full scale and every bit boundary.
- R7: A rising edge of sample_clk_i during a conversion does not restart it. The conversion completes with one done pulse and a correct code.
- R8: code_o changes only in a cycle where done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_clk_i | input | 1 | Sampling clock; its rising edge starts a conversion |
| cmp_p_i | input | 1 | Positive comparator rail, high while the comparator is in reset |
| cmp_n_i | input | 1 | Negative comparator rail, high while the comparator is in reset |
| cmp_clk_o | output | 1 | Comparator clock; high holds the comparator in reset |
| step_o | output | NB | One-hot bit-step chain, MSB first; zero when parked |
| plate_gnd_o | output | NB | Per-bit bottom-plate select, 1 = ground, 0 = reference |
| code_o | output | NB | Conversion result, bit k = decision for bit k |
| done_o | output | 1 | One-cycle end-of-conversion pulse |

## Verification
A behavioural top-plate array and comparator in the bench subtract the grounded weights from the sampled input and decide each step. The result is compared with an ideal quantiser computed from the input alone. The input is given in quarter-LSB resolution. Zero, full scale, and the values one quarter below and exactly on each power-of-two boundary show whether every bit decides on the correct side of its threshold. Those values also catch plates that are switched late or in the wrong order. Seeded random inputs cover mixed bit patterns. A conversion that receives an extra sampling edge partway through shows that a restart is refused and that a brief comparator hold does not upset the sequence.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;
  // Default resolution of the converter.
  parameter int unsigned SAR_BITS_DEF = 10;
endpackage

// File: rtl/sar_step_chain.sv
module sar_step_chain #(
  parameter int unsigned NB = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          fire,
  output logic [NB-1:0] step,
  output logic          parked
);
  localparam logic [NB-1:0] FIRST = {1'b1, {(NB-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      step   <= '0;
      parked <= 1'b1;
    end else if (start) begin
      step   <= FIRST;
      parked <= 1'b0;
    end else if (fire && !parked) begin
      step   <= step >> 1;
      parked <= step[0];
    end
  end
endmodule

// File: rtl/sar_bit_cell.sv
module sar_bit_cell (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic stage_en,
  input  logic fire,
  input  logic dec_in,
  output logic dec,
  output logic en_d,
  output logic plate_gnd
);
  always_ff @(posedge clk) begin
    if (rst || start) begin
      dec       <= 1'b0;
      en_d      <= 1'b0;
      plate_gnd <= 1'b0;
    end else begin
      if (stage_en && fire) dec <= dec_in;
      // Delayed step: the plate moves one cycle after the decision latch.
      en_d <= stage_en && fire;
      if (en_d && dec) plate_gnd <= 1'b1;
    end
  end
endmodule

// File: rtl/tps_sar_ctrl.sv
module tps_sar_ctrl
  import sar_ctrl_pkg::*;
#(
  parameter int unsigned NB = SAR_BITS_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sample_clk_i,
  input  logic          cmp_p_i,
  input  logic          cmp_n_i,
  output logic          cmp_clk_o,
  output logic [NB-1:0] step_o,
  output logic [NB-1:0] plate_gnd_o,
  output logic [NB-1:0] code_o,
  output logic          done_o
);
  logic          samp_q;
  logic          valid_q;
  logic          valid;
  logic          fire;
  logic          start;
  logic          parked;
  logic [NB-1:0] dec;
  logic [NB-1:0] en_d;

  assign valid = ~(cmp_p_i & cmp_n_i);
  assign fire  = valid & ~valid_q;
  assign start = sample_clk_i & ~samp_q & parked;

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_q    <= 1'b0;
      valid_q   <= 1'b0;
      cmp_clk_o <= 1'b1;
      done_o    <= 1'b0;
      code_o    <= '0;
    end else begin
      samp_q    <= sample_clk_i;
      valid_q   <= valid;
      cmp_clk_o <= sample_clk_i | valid | parked;
      done_o    <= en_d[0];
      if (en_d[0]) code_o <= dec;
    end
  end

  sar_step_chain #(.NB(NB)) chain_i (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .fire   (fire),
    .step   (step_o),
    .parked (parked)
  );

  for (genvar g = 0; g < NB; g++) begin : g_bit
    sar_bit_cell cell_i (
      .clk       (clk),
      .rst       (rst),
      .start     (start),
      .stage_en  (step_o[g]),
      .fire      (fire),
      .dec_in    (cmp_p_i),
      .dec       (dec[g]),
      .en_d      (en_d[g]),
      .plate_gnd (plate_gnd_o[g])
    );
  end
endmodule

// File: rtl/tps_sar_ctrl_chk.sv
module tps_sar_ctrl_chk #(
  parameter int unsigned NB = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          sample_clk_i,
  input logic          cmp_p_i,
  input logic          cmp_n_i,
  input logic          cmp_clk_o,
  input logic [NB-1:0] step_o,
  input logic [NB-1:0] plate_gnd_o,
  input logic [NB-1:0] code_o,
  input logic          done_o,
  input logic          parked
);
  localparam logic [NB-1:0] FIRST = {1'b1, {(NB-1){1'b0}}};

  assert_cmp_clk_R3: assert property (@(posedge clk) disable iff (rst)
    cmp_clk_o == ($past(sample_clk_i) | ~($past(cmp_p_i) & $past(cmp_n_i)) | $past(parked)));

  assert_start_R2: assert property (@(posedge clk) disable iff (rst)
    (sample_clk_i && !$past(sample_clk_i) && parked) |=> (step_o == FIRST && plate_gnd_o == '0));

  assert_onehot_step_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(step_o));

  assert_park_empty_R4: assert property (@(posedge clk) disable iff (rst)
    parked |-> (step_o == '0));

  assert_plate_monotonic_R5: assert property (@(posedge clk) disable iff (rst)
    (|($past(plate_gnd_o) & ~plate_gnd_o)) |-> (step_o == FIRST));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_code_matches_plates_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (code_o == plate_gnd_o));

  assert_code_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(code_o));
endmodule

bind tps_sar_ctrl tps_sar_ctrl_chk #(.NB(NB)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .sample_clk_i (sample_clk_i),
  .cmp_p_i      (cmp_p_i),
  .cmp_n_i      (cmp_n_i),
  .cmp_clk_o    (cmp_clk_o),
  .step_o       (step_o),
  .plate_gnd_o  (plate_gnd_o),
  .code_o       (code_o),
  .done_o       (done_o),
  .parked       (parked)
);

// File: tb/tps_sar_ctrl_tb_top.sv
module tps_sar_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 10;
  localparam int SEED = 1234;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_clk = 1'b0;
  logic cmp_p = 1'b1;
  logic cmp_n = 1'b1;
  logic cmp_clk;
  logic [NB-1:0] step, plate, code;
  logic done;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tps_sar_ctrl #(.NB(NB)) dut_i (
    .clk(clk), .rst(rst), .sample_clk_i(sample_clk),
    .cmp_p_i(cmp_p), .cmp_n_i(cmp_n), .cmp_clk_o(cmp_clk),
    .step_o(step), .plate_gnd_o(plate), .code_o(code), .done_o(done)
  );

  // Ideal quantiser: input in quarter-LSB units.
  function automatic int ideal_code(int vq);
    return vq >> 2;
  endfunction

  function automatic int one_idx(logic [NB-1:0] v);
    int r = -1;
    for (int i = 0; i < NB; i++) if (v[i]) r = i;
    return r;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One conversion with behavioural top-plate array and comparator.
  task automatic convert(int vq, bit poke);
    int expk = NB - 1;
    bit first = 1'b1;
    bit mono_ok = 1'b1;
    bit order_ok = 1'b1;
    int dones = 0;
    int after = -1;
    logic [NB-1:0] prev = '0;
    @(negedge clk) sample_clk = 1'b1;
    @(negedge clk);
    @(negedge clk) sample_clk = 1'b0;
    for (int cyc = 0; cyc < 120 && after != 0; cyc++) begin
      @(negedge clk);
      sample_clk = (poke && cyc == 8);
      if (after > 0) begin
        after--;
        chk(!done, "R6 done width", done, 0);
      end
      if ((prev & ~plate) != '0) mono_ok = 1'b0;
      prev = plate;
      if (done && after < 0) begin
        dones++;
        chk(code == NB'(ideal_code(vq)), "R6 code", code, ideal_code(vq));
        chk(plate == code, "R6 plates vs code", plate, code);
        after = 2;
      end
      if (cmp_clk) begin
        cmp_p = 1'b1; cmp_n = 1'b1;
      end else if (step != '0) begin
        int k = one_idx(step);
        int resid = vq;
        bit d;
        if (first) begin
          chk(plate == '0, "R2 first compare plates", plate, 0);
          chk(k == NB - 1, "R2 first step", k, NB - 1);
          first = 1'b0;
        end
        if (k != expk) order_ok = 1'b0;
        expk--;
        for (int i = 0; i < NB; i++) if (plate[i]) resid -= 4 * (1 << i);
        d = (resid >= 4 * (1 << k));
        cmp_p = d; cmp_n = ~d;
      end
    end
    cmp_p = 1'b1; cmp_n = 1'b1; sample_clk = 1'b0;
    chk(mono_ok, "R5 plate monotonic", mono_ok, 1);
    chk(order_ok && expk == -1, "R4 step order", expk, -1);
    chk(dones == 1, poke ? "R7 done count" : "R6 done count", dones, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int r;
    logic [NB-1:0] held;
    r = $urandom(SEED);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(plate == '0, "R1 plates", plate, 0);
    chk(step == '0, "R1 step", step, 0);
    chk(code == '0, "R1 code", code, 0);
    chk(!done, "R1 done", done, 0);
    chk(cmp_clk, "R1 cmp_clk", cmp_clk, 1);
    rst = 1'b0;
    @(negedge clk);
    // R3 parked: comparator clock held high
    chk(cmp_clk, "R3 parked cmp_clk", cmp_clk, 1);
    // R6 corner inputs: zero, full scale, midscale
    convert(0, 0);
    convert(4095, 0);
    convert(2047, 0);
    convert(2048, 0);
    // R6 each bit boundary, a quarter below and exactly on it
    for (int k = 0; k < NB; k++) begin
      convert(4 * (1 << k) - 1, 0);
      convert(4 * (1 << k), 0);
    end
    // R7 extra sampling edge mid-conversion
    convert(1234 * 3, 1);
    // R6 random inputs
    for (int i = 0; i < 30; i++) convert(int'($urandom % 4096), 0);
    // R8 code held while idle
    held = code;
    repeat (10) @(negedge clk);
    chk(code == held, "R8 code held", code, held);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule